// File: doc/BRIEF.md
# Multicycle Datapath Control Sequencer

This block is the state machine that steers a multicycle processor datapath. Each instruction takes several clock cycles. In every cycle the sequencer drives a fixed set of select and enable lines: the memory address source, the memory read strobe, the instruction register load, the program counter write and its source, the two ALU operand selects, the ALU operation class, and the register file write controls. It is a Moore machine, so every output depends on the current state alone.

Every instruction starts with a fetch cycle and then a decode cycle. The fetch cycle uses the single ALU to add four to the program counter. The decode cycle uses the same ALU to precompute a branch target from the shifted immediate. The 6-bit major opcode is examined only at the end of the decode cycle. A register-to-register operation then takes an execute cycle and a write-back cycle. A word load takes an address cycle, a memory read cycle and a write-back cycle. Any other opcode goes straight back to fetch. The surrounding datapath owns the instruction register and supplies the opcode.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, the state is fetch and the outputs show the fetch pattern given in R2.
- R2: Fetch drives mem_rd_o=1, ir_we_o=1, pc_we_o=1, pc_sel_o=01, alu_b_sel_o=01, alu_a_sel_o=0, alu_op_o=00 and mem_addr_sel_o=0. All other outputs are 0.
- R3: Fetch is always followed by decode. Decode drives alu_b_sel_o=11, alu_a_sel_o=0 and alu_op_o=00. All other outputs are 0.
- R4: If opcode_i is 000000 at the end of decode, the next states are execute, then register write-back, then fetch.
- R5: Execute drives alu_a_sel_o=1, alu_b_sel_o=00 and alu_op_o=10 (the operation is taken from the function field). All other outputs are 0.
- R6: Register write-back drives rf_we_o=1, rf_dst_o=1 and rf_wsel_o=0. All other outputs are 0.
- R7: If opcode_i is 100011 at the end of decode, the next states are address, then memory read, then load write-back, then fetch.
- R8: The address state drives alu_a_sel_o=1, alu_b_sel_o=10 and alu_op_o=00. All other outputs are 0.
- R9: The memory read state drives mem_addr_sel_o=1 and mem_rd_o=1. All other outputs are 0.
- R10: Load write-back drives rf_we_o=1, rf_wsel_o=1 and rf_dst_o=0. All other outputs are 0.
- R11: Any other opcode at the end of decode returns the machine to fetch in the next cycle.
- R12: The value of opcode_i in any state other than decode has no effect on the state sequence or on the outputs.
- R13: Whenever rf_we_o is 1, ir_we_o, pc_we_o and mem_rd_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Major opcode field of the instruction register |
| mem_addr_sel_o | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd_o | output | 1 | Memory read strobe |
| ir_we_o | output | 1 | Instruction register load enable |
| pc_we_o | output | 1 | Program counter write enable |
| pc_sel_o | output | 2 | Program counter source select |
| alu_a_sel_o | output | 1 | ALU operand A select: 0 program counter, 1 register A |
| alu_b_sel_o | output | 2 | ALU operand B select: 00 reg B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | ALU operation class: 00 add, 10 from function field |
| rf_we_o | output | 1 | Register file write enable |
| rf_wsel_o | output | 1 | Register write data: 0 ALU result, 1 memory data |
| rf_dst_o | output | 1 | Destination field select: 0 rt, 1 rd |

## Verification
The hardest case to reach is proving that the opcode is ignored outside decode. The datapath would normally hold the opcode steady through the whole instruction, so a change at any other time never shows up on its own. The stimulus therefore drives the inverted opcode during fetch and switches to the real value only inside the window before decode ends. For multicycle instructions it then replaces the opcode with a different value in the first type-specific state. The scoreboard expects the full state pattern sequence anyway. Unsupported opcodes are placed back to back with supported ones, so that the early return to fetch and the next fetch join without a gap.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_ADDR   = 3'd2,
    ST_MRD    = 3'd3,
    ST_LWB    = 3'd4,
    ST_EXEC   = 3'd5,
    ST_RWB    = 3'd6
  } state_e;

  typedef struct packed {
    logic       mem_addr_sel;
    logic       mem_rd;
    logic       ir_we;
    logic       pc_we;
    logic [1:0] pc_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       rf_we;
    logic       rf_wsel;
    logic       rf_dst;
  } ctrl_t;

  localparam logic       ADDR_PC     = 1'b0;
  localparam logic       ADDR_ALUREG = 1'b1;
  localparam logic       A_PC        = 1'b0;
  localparam logic       A_REG       = 1'b1;
  localparam logic [1:0] B_REG       = 2'b00;
  localparam logic [1:0] B_FOUR      = 2'b01;
  localparam logic [1:0] B_IMM       = 2'b10;
  localparam logic [1:0] B_IMM_SHL   = 2'b11;
  localparam logic [1:0] OP_ADD      = 2'b00;
  localparam logic [1:0] OP_FUNCT    = 2'b10;
  localparam logic [1:0] PC_SEL_SEQ  = 2'b01;
  localparam logic       WSEL_ALU    = 1'b0;
  localparam logic       WSEL_MEM    = 1'b1;
  localparam logic       DST_RT      = 1'b0;
  localparam logic       DST_RD      = 1'b1;

endpackage

// File: rtl/mc_ctrl_opdec.sv
module mc_ctrl_opdec #(
  parameter int unsigned     OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = '0,
  parameter logic [OP_W-1:0] OP_LOAD  = '1
) (
  input  logic [OP_W-1:0] opcode_i,
  output logic            is_rtype_o,
  output logic            is_load_o
);

  assign is_rtype_o = (opcode_i == OP_RTYPE);
  assign is_load_o  = (opcode_i == OP_LOAD);

endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  input  logic   is_rtype_i,
  input  logic   is_load_i,
  output state_e state_o
);

  always_comb begin
    state_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  state_o = ST_DECODE;
      ST_DECODE: begin
        if (is_rtype_i)     state_o = ST_EXEC;
        else if (is_load_i) state_o = ST_ADDR;
        else                state_o = ST_FETCH;
      end
      ST_ADDR:   state_o = ST_MRD;
      ST_MRD:    state_o = ST_LWB;
      ST_LWB:    state_o = ST_FETCH;
      ST_EXEC:   state_o = ST_RWB;
      ST_RWB:    state_o = ST_FETCH;
      default:   state_o = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  // Unlisted fields stay zero in every state: no stray writes.
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_addr_sel = ADDR_PC;
        ctrl_o.mem_rd       = 1'b1;
        ctrl_o.ir_we        = 1'b1;
        ctrl_o.pc_we        = 1'b1;
        ctrl_o.pc_sel       = PC_SEL_SEQ;
        ctrl_o.alu_a_sel    = A_PC;
        ctrl_o.alu_b_sel    = B_FOUR;
        ctrl_o.alu_op       = OP_ADD;
      end
      ST_DECODE: begin
        ctrl_o.alu_a_sel    = A_PC;
        ctrl_o.alu_b_sel    = B_IMM_SHL;
        ctrl_o.alu_op       = OP_ADD;
      end
      ST_ADDR: begin
        ctrl_o.alu_a_sel    = A_REG;
        ctrl_o.alu_b_sel    = B_IMM;
        ctrl_o.alu_op       = OP_ADD;
      end
      ST_MRD: begin
        ctrl_o.mem_addr_sel = ADDR_ALUREG;
        ctrl_o.mem_rd       = 1'b1;
      end
      ST_LWB: begin
        ctrl_o.rf_we        = 1'b1;
        ctrl_o.rf_wsel      = WSEL_MEM;
        ctrl_o.rf_dst       = DST_RT;
      end
      ST_EXEC: begin
        ctrl_o.alu_a_sel    = A_REG;
        ctrl_o.alu_b_sel    = B_REG;
        ctrl_o.alu_op       = OP_FUNCT;
      end
      ST_RWB: begin
        ctrl_o.rf_we        = 1'b1;
        ctrl_o.rf_wsel      = WSEL_ALU;
        ctrl_o.rf_dst       = DST_RD;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned     OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic            mem_addr_sel_o,
  output logic            mem_rd_o,
  output logic            ir_we_o,
  output logic            pc_we_o,
  output logic [1:0]      pc_sel_o,
  output logic            alu_a_sel_o,
  output logic [1:0]      alu_b_sel_o,
  output logic [1:0]      alu_op_o,
  output logic            rf_we_o,
  output logic            rf_wsel_o,
  output logic            rf_dst_o
);

  state_e state_q, state_d;
  logic   is_rtype, is_load;
  ctrl_t  ctrl;

  mc_ctrl_opdec #(
    .OP_W     (OP_W),
    .OP_RTYPE (OP_RTYPE),
    .OP_LOAD  (OP_LOAD)
  ) i_opdec (
    .opcode_i   (opcode_i),
    .is_rtype_o (is_rtype),
    .is_load_o  (is_load)
  );

  mc_ctrl_next i_next (
    .state_i    (state_q),
    .is_rtype_i (is_rtype),
    .is_load_i  (is_load),
    .state_o    (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  mc_ctrl_out i_out (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  assign mem_addr_sel_o = ctrl.mem_addr_sel;
  assign mem_rd_o       = ctrl.mem_rd;
  assign ir_we_o        = ctrl.ir_we;
  assign pc_we_o        = ctrl.pc_we;
  assign pc_sel_o       = ctrl.pc_sel;
  assign alu_a_sel_o    = ctrl.alu_a_sel;
  assign alu_b_sel_o    = ctrl.alu_b_sel;
  assign alu_op_o       = ctrl.alu_op;
  assign rf_we_o        = ctrl.rf_we;
  assign rf_wsel_o      = ctrl.rf_wsel;
  assign rf_dst_o       = ctrl.rf_dst;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned     OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] opcode_i,
  input state_e          state_i,
  input logic            mem_addr_sel_i,
  input logic            mem_rd_i,
  input logic            ir_we_i,
  input logic            pc_we_i,
  input logic            rf_we_i,
  input logic            rf_dst_i,
  input logic            rf_wsel_i
);

  a_r3_fetch_then_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> state_i == ST_DECODE);

  a_r4_rtype_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE && opcode_i == OP_RTYPE) |=> state_i == ST_EXEC);

  a_r6_exec_to_rwb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_EXEC |=> (rf_we_i && rf_dst_i && !rf_wsel_i));

  a_r7_load_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE && opcode_i == OP_LOAD) |=> state_i == ST_ADDR);

  a_r9_addr_to_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_ADDR |=> (mem_addr_sel_i && mem_rd_i));

  a_r10_lwb_to_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_LWB |=> (ir_we_i && pc_we_i && !mem_addr_sel_i));

  a_r11_other_to_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE && opcode_i != OP_RTYPE && opcode_i != OP_LOAD)
      |=> state_i == ST_FETCH);

  a_r13_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> (!ir_we_i && !pc_we_i && !mem_rd_i));

endmodule

bind mc_ctrl_fsm mc_ctrl_chk #(
  .OP_W     (OP_W),
  .OP_RTYPE (OP_RTYPE),
  .OP_LOAD  (OP_LOAD)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .opcode_i       (opcode_i),
  .state_i        (state_q),
  .mem_addr_sel_i (mem_addr_sel_o),
  .mem_rd_i       (mem_rd_o),
  .ir_we_i        (ir_we_o),
  .pc_we_i        (pc_we_o),
  .rf_we_i        (rf_we_o),
  .rf_dst_i       (rf_dst_o),
  .rf_wsel_i      (rf_wsel_o)
);

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'd0;
  logic       mem_addr_sel_o, mem_rd_o, ir_we_o, pc_we_o;
  logic [1:0] pc_sel_o, alu_b_sel_o, alu_op_o;
  logic       alu_a_sel_o, rf_we_o, rf_wsel_o, rf_dst_o;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .opcode_i       (opcode_i),
    .mem_addr_sel_o (mem_addr_sel_o),
    .mem_rd_o       (mem_rd_o),
    .ir_we_o        (ir_we_o),
    .pc_we_o        (pc_we_o),
    .pc_sel_o       (pc_sel_o),
    .alu_a_sel_o    (alu_a_sel_o),
    .alu_b_sel_o    (alu_b_sel_o),
    .alu_op_o       (alu_op_o),
    .rf_we_o        (rf_we_o),
    .rf_wsel_o      (rf_wsel_o),
    .rf_dst_o       (rf_dst_o)
  );

  always #2 clk_i = ~clk_i;

  // Vector: {addr_sel, mem_rd, ir_we, pc_we, pc_sel[1:0], a_sel, b_sel[1:0], op[1:0], rf_we, wsel, dst}
  localparam logic [14:0] V_FETCH  = {1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0};
  localparam logic [14:0] V_DECODE = {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0};
  localparam logic [14:0] V_EXEC   = {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0};
  localparam logic [14:0] V_RWB    = {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1};
  localparam logic [14:0] V_ADDR   = {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0};
  localparam logic [14:0] V_MRD    = {1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0};
  localparam logic [14:0] V_LWB    = {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0};

  logic [14:0] exp_q[$];
  string       req_q[$];
  int          pending = 0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  function automatic logic [14:0] obs();
    return {mem_addr_sel_o, mem_rd_o, ir_we_o, pc_we_o, pc_sel_o, alu_a_sel_o,
            alu_b_sel_o, alu_op_o, rf_we_o, rf_wsel_o, rf_dst_o};
  endfunction

  task automatic push(input logic [14:0] v, input string r);
    exp_q.push_back(v);
    req_q.push_back(r);
    pending++;
  endtask

  // Monitor: compare one expected pattern per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (pending > 0) begin
        logic [14:0] e;
        string       r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        n_run++;
        if (obs() !== e) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", r, obs(), e);
        end
        pending--;
      end
    end
  end

  // Driver: queue the expected sequence; drive junk outside decode (R12)
  task automatic run_instr(input logic [5:0] op);
    wait (pending == 0);
    push(V_FETCH, "R2 fetch");
    push(V_DECODE, "R3 decode");
    if (op == 6'b000000) begin
      push(V_EXEC, "R4/R5 execute");
      push(V_RWB,  "R4/R6 register write-back");
    end else if (op == 6'b100011) begin
      push(V_ADDR, "R7/R8 address");
      push(V_MRD,  "R7/R9 memory read");
      push(V_LWB,  "R7/R10 load write-back");
    end else begin
      push(V_FETCH, "R11 unsupported returns to fetch");
      pending--;
      void'(exp_q.pop_back());
      void'(req_q.pop_back());
    end
    @(posedge clk_i); #1;
    opcode_i = ~op;            // R12: junk during fetch
    @(negedge clk_i); #1;
    opcode_i = op;             // valid before decode ends
    if (op == 6'b000000 || op == 6'b100011) begin
      @(negedge clk_i); #1;
      @(negedge clk_i); #1;
      opcode_i = (op == 6'b000000) ? 6'b100011 : 6'b000000; // R12: conflicting opcode later
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    opcode_i = 6'b000000;
    repeat (3) begin
      @(negedge clk_i);
      n_run++;
      if (obs() !== V_FETCH) begin
        n_fail++;
        $display("FAIL R1 reset: got %b expected %b", obs(), V_FETCH);
      end
    end
    #1;
    fork
      begin @(posedge clk_i); #1; rst_ni = 1'b1; end
    join_none
    run_instr(6'b000000);
    run_instr(6'b100011);
    run_instr(6'b101011);   // R11: store-like code unsupported
    run_instr(6'b000100);   // R11
    run_instr(6'b000000);
    run_instr(6'b000000);
    run_instr(6'b111111);   // R11
    run_instr(6'b100011);
    run_instr(6'b100011);
    run_instr(6'b000001);   // R11: one bit from R-type
    run_instr(6'b100010);   // R11: one bit from load
    run_instr(6'b000000);
    wait (pending == 0);
    @(negedge clk_i);
    // Next cycle after final register write-back must be fetch (R4)
    n_run++;
    if (obs() !== V_FETCH) begin
      n_fail++;
      $display("FAIL R4 return to fetch: got %b expected %b", obs(), V_FETCH);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule